// File: doc/BRIEF.md
# Fabric Checksum Guard

This block wraps an internal switch fabric with two byte-wide streaming paths. On the way in, every received Ethernet frame is held in a local buffer while its CRC-32 frame check sequence is checked. A damaged frame is discarded before any of it reaches the fabric. A sound frame has its four check bytes removed. It is then sent into the fabric behind a two-byte integrity header, which is a 16-bit end-around-carry sum over the payload.

On the way out, the two header bytes are taken off the fabric stream and the same sum is recomputed over the payload as it passes. The payload leaves unchanged, whether or not the sums agree. A disagreement raises an error flag on the last byte and adds one to a saturating error counter for the egress port. Any counter can be read, and cleared, by its port number.

Top module: `fab_csum_guard`

## Requirements
- R1: The ingress path takes bytes (`in_ready_o` high) only while collecting a frame. No byte of a frame appears at the fabric output before the frame's last byte has been accepted, and `in_ready_o` stays low while a frame is being sent to the fabric.
- R2: A frame passes the CRC check only if a reflected CRC-32 register reads 0xDEBB20E3 after all bytes, check bytes included, have been clocked in. The register uses polynomial 0xEDB88320 shifted right and is preset to 0xFFFFFFFF. A sender forms the check bytes by inverting the register after the payload and sending it least significant byte first.
- R3: A frame that fails the CRC check produces no fabric output, and the ingress path is ready for the next frame in the following cycle.
- R4: Frames with fewer than 5 bytes, or more than MAX_BYTES bytes counting the check bytes, are dropped with no fabric output.
- R5: A frame that passes is sent to the fabric in this order: the header high byte, the header low byte, then the payload without the check bytes. `fab_last_o` is high on the final payload byte only. The header is the 16-bit end-around-carry sum of the payload words, not inverted. In each word the even-index byte is the high half, and an odd final byte is padded with a zero low half.
- R6: While `fab_valid_o` is high and `fab_ready_i` is low, the fabric output data, last flag and valid hold their values.
- R7: The egress path consumes the first two bytes of each frame from the fabric as the header and produces no output for them. Every later byte is forwarded unchanged, with its last flag, whether or not the frame's checksum matches.
- R8: `out_err_o` is high on the last output byte of a frame if the sum recomputed over the payload differs from the header, and low on every other byte.
- R9: Each mismatching frame adds one to the error counter of the port given on `eg_port_i` with its last byte. A counter at all-ones stays there, and the other ports' counters do not change.
- R10: `cnt_val_o` shows the counter selected by `cnt_idx_i` in the same cycle. `cnt_clr_i` sets that counter to zero at the next edge, and the clear takes priority over an increment in the same cycle.
- R11: After reset, every counter reads zero, `in_ready_o` is high and `fab_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Received frame byte |
| in_valid_i | input | 1 | Received byte valid |
| in_last_i | input | 1 | Last byte of the received frame |
| in_ready_o | output | 1 | Ingress path accepts a byte |
| fab_data_o | output | 8 | Byte into the fabric |
| fab_valid_o | output | 1 | Fabric byte valid |
| fab_last_o | output | 1 | Last byte into the fabric |
| fab_ready_i | input | 1 | Fabric accepts a byte |
| eg_data_i | input | 8 | Byte from the fabric |
| eg_valid_i | input | 1 | Fabric byte valid |
| eg_last_i | input | 1 | Last byte from the fabric |
| eg_port_i | input | PORT_W | Egress port of the current frame |
| eg_ready_o | output | 1 | Egress path accepts a byte |
| out_data_o | output | 8 | Outgoing payload byte |
| out_valid_o | output | 1 | Outgoing byte valid |
| out_last_o | output | 1 | Last outgoing byte |
| out_err_o | output | 1 | Checksum mismatch, on the last byte |
| out_ready_i | input | 1 | Downstream accepts a byte |
| cnt_idx_i | input | PORT_W | Counter select |
| cnt_clr_i | input | 1 | Clear the selected counter |
| cnt_val_o | output | CNT_W | Selected counter value |

## Verification
The ingress path is swept over every payload length from one byte to the buffer limit, with varied byte patterns and a stalling fabric on odd lengths. This separates the word pairing of odd and even lengths, the end-around carry, and the removal of the check bytes. The payload lengths around the limit, a check-byte-only frame, a corrupted payload and a corrupted check byte separate each drop condition from the accepted case. The egress path is driven with matching headers and with headers that differ by one bit, on every port and with a stalling receiver. It is also driven with frames taken straight from the ingress output. The counters are pushed past saturation on one port while the other ports are read, and then cleared.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT    = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  function automatic logic [15:0] csum_add(logic [15:0] a, logic [15:0] v);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, v};
    return s[15:0] + {15'h0, s[16]};
  endfunction

  function automatic logic [15:0] csum_lane(logic [7:0] b, logic odd);
    return odd ? {8'h0, b} : {b, 8'h0};
  endfunction
endpackage

// File: rtl/fcg_ingress.sv
module fcg_ingress #(
  parameter int MAX_BYTES = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] in_data_i,
  input  logic       in_valid_i,
  input  logic       in_last_i,
  output logic       in_ready_o,
  output logic [7:0] fab_data_o,
  output logic       fab_valid_o,
  output logic       fab_last_o,
  input  logic       fab_ready_i
);
  import fcg_pkg::*;
  localparam int IW    = $clog2(MAX_BYTES + 1);
  localparam int DEPTH = 2 ** IW;

  logic [7:0]    mem [DEPTH];
  logic          sending, ovf;
  logic [IW-1:0] cnt, plen, scnt, add_idx;
  logic [31:0]   crc, crc_nx;
  logic [15:0]   csum, csum_nx, hdr;
  logic          acc, add_en, good, full;

  assign acc     = in_valid_i && !sending;
  assign full    = (cnt == IW'(MAX_BYTES));
  assign crc_nx  = crc_step(crc, in_data_i);
  // checksum trails the write pointer by 4 so FCS bytes never enter it
  assign add_en  = (cnt >= IW'(4)) && !ovf;
  assign add_idx = cnt - IW'(4);
  assign csum_nx = add_en ? csum_add(csum, csum_lane(mem[add_idx], add_idx[0])) : csum;
  assign good    = (crc_nx == CRC_RESIDUE) && !ovf && !full && (cnt >= IW'(4));

  assign in_ready_o  = !sending;
  assign fab_valid_o = sending;
  assign fab_last_o  = sending && (scnt == plen + IW'(1));
  always_comb begin
    if (scnt == '0)         fab_data_o = hdr[15:8];
    else if (scnt == IW'(1)) fab_data_o = hdr[7:0];
    else                     fab_data_o = mem[scnt - IW'(2)];
  end

  always_ff @(posedge clk_i) begin
    if (acc && !full) mem[cnt] <= in_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sending <= 1'b0;
      ovf     <= 1'b0;
      cnt     <= '0;
      plen    <= '0;
      scnt    <= '0;
      crc     <= CRC_INIT;
      csum    <= '0;
      hdr     <= '0;
    end else if (acc) begin
      if (in_last_i) begin
        cnt  <= '0;
        ovf  <= 1'b0;
        crc  <= CRC_INIT;
        csum <= '0;
        if (good) begin
          sending <= 1'b1;
          plen    <= cnt - IW'(3);
          hdr     <= csum_nx;
          scnt    <= '0;
        end
      end else begin
        crc  <= crc_nx;
        csum <= csum_nx;
        if (full) ovf <= 1'b1;
        else      cnt <= cnt + IW'(1);
      end
    end else if (sending && fab_ready_i) begin
      if (fab_last_o) begin
        sending <= 1'b0;
        scnt    <= '0;
      end else begin
        scnt <= scnt + IW'(1);
      end
    end
  end
endmodule

// File: rtl/fcg_egress.sv
module fcg_egress #(
  parameter int PORT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        eg_data_i,
  input  logic              eg_valid_i,
  input  logic              eg_last_i,
  input  logic [PORT_W-1:0] eg_port_i,
  output logic              eg_ready_o,
  output logic [7:0]        out_data_o,
  output logic              out_valid_o,
  output logic              out_last_o,
  output logic              out_err_o,
  input  logic              out_ready_i,
  output logic              err_evt_o,
  output logic [PORT_W-1:0] err_port_o
);
  import fcg_pkg::*;

  logic [1:0]  hcnt;
  logic        odd, in_data_ph, mism;
  logic [15:0] hdr, acc, acc_nx;

  assign in_data_ph  = (hcnt == 2'd2);
  assign eg_ready_o  = in_data_ph ? out_ready_i : 1'b1;
  assign out_valid_o = eg_valid_i && in_data_ph;
  assign out_data_o  = eg_data_i;
  assign out_last_o  = eg_last_i && in_data_ph;
  assign acc_nx      = csum_add(acc, csum_lane(eg_data_i, odd));
  assign mism        = (acc_nx != hdr);
  assign out_err_o   = out_valid_o && eg_last_i && mism;
  assign err_evt_o   = out_err_o && out_ready_i;
  assign err_port_o  = eg_port_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt <= '0;
      odd  <= 1'b0;
      hdr  <= '0;
      acc  <= '0;
    end else if (eg_valid_i && eg_ready_o) begin
      if (eg_last_i) begin
        hcnt <= '0;
        odd  <= 1'b0;
        acc  <= '0;
      end else if (hcnt == 2'd0) begin
        hdr[15:8] <= eg_data_i;
        hcnt      <= 2'd1;
      end else if (hcnt == 2'd1) begin
        hdr[7:0] <= eg_data_i;
        hcnt     <= 2'd2;
      end else begin
        acc <= acc_nx;
        odd <= !odd;
      end
    end
  end
endmodule

// File: rtl/fcg_err_cnt.sv
module fcg_err_cnt #(
  parameter int NPORTS = 4,
  parameter int CNT_W  = 32,
  parameter int PORT_W = $clog2(NPORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [PORT_W-1:0] evt_port_i,
  input  logic [PORT_W-1:0] idx_i,
  input  logic              clr_i,
  output logic [CNT_W-1:0]  val_o
);
  logic [CNT_W-1:0] cnts [NPORTS];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                             cnts[p] <= '0;
      else if (clr_i && idx_i == PORT_W'(p))                   cnts[p] <= '0;
      else if (evt_i && evt_port_i == PORT_W'(p) && cnts[p] != '1) cnts[p] <= cnts[p] + 1'b1;
    end
  end

  assign val_o = cnts[idx_i];
endmodule

// File: rtl/fab_csum_guard.sv
module fab_csum_guard #(
  parameter int MAX_BYTES = 64,
  parameter int NPORTS    = 4,
  parameter int CNT_W     = 32,
  parameter int PORT_W    = $clog2(NPORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        in_data_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic [7:0]        fab_data_o,
  output logic              fab_valid_o,
  output logic              fab_last_o,
  input  logic              fab_ready_i,
  input  logic [7:0]        eg_data_i,
  input  logic              eg_valid_i,
  input  logic              eg_last_i,
  input  logic [PORT_W-1:0] eg_port_i,
  output logic              eg_ready_o,
  output logic [7:0]        out_data_o,
  output logic              out_valid_o,
  output logic              out_last_o,
  output logic              out_err_o,
  input  logic              out_ready_i,
  input  logic [PORT_W-1:0] cnt_idx_i,
  input  logic              cnt_clr_i,
  output logic [CNT_W-1:0]  cnt_val_o
);
  logic              err_evt;
  logic [PORT_W-1:0] err_port;

  fcg_ingress #(.MAX_BYTES(MAX_BYTES)) u_ing (
    .clk_i, .rst_ni, .in_data_i, .in_valid_i, .in_last_i, .in_ready_o,
    .fab_data_o, .fab_valid_o, .fab_last_o, .fab_ready_i
  );

  fcg_egress #(.PORT_W(PORT_W)) u_eg (
    .clk_i, .rst_ni, .eg_data_i, .eg_valid_i, .eg_last_i, .eg_port_i, .eg_ready_o,
    .out_data_o, .out_valid_o, .out_last_o, .out_err_o, .out_ready_i,
    .err_evt_o(err_evt), .err_port_o(err_port)
  );

  fcg_err_cnt #(.NPORTS(NPORTS), .CNT_W(CNT_W), .PORT_W(PORT_W)) u_cnt (
    .clk_i, .rst_ni, .evt_i(err_evt), .evt_port_i(err_port),
    .idx_i(cnt_idx_i), .clr_i(cnt_clr_i), .val_o(cnt_val_o)
  );
endmodule

// File: rtl/fab_csum_guard_chk.sv
module fab_csum_guard_chk #(
  parameter int CNT_W  = 32,
  parameter int PORT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic [7:0]        fab_data_o,
  input logic              fab_valid_o,
  input logic              fab_last_o,
  input logic              fab_ready_i,
  input logic              eg_valid_i,
  input logic              out_valid_o,
  input logic              out_last_o,
  input logic              out_err_o,
  input logic [PORT_W-1:0] cnt_idx_i,
  input logic              cnt_clr_i,
  input logic [CNT_W-1:0]  cnt_val_o
);
  a_r1_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fab_valid_o |-> !in_ready_o);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fab_valid_o && !fab_ready_i) |=> (fab_valid_o && $stable(fab_data_o) && $stable(fab_last_o)));

  a_r7_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> eg_valid_i);

  a_r8_err_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_err_o |-> (out_valid_o && out_last_o));

  a_r9_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_val_o == '1 && !cnt_clr_i) |=> (!$stable(cnt_idx_i) || cnt_val_o == '1));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (!$stable(cnt_idx_i) || cnt_val_o == '0));
endmodule

bind fab_csum_guard fab_csum_guard_chk #(.CNT_W(CNT_W), .PORT_W(PORT_W)) u_chk (
  .clk_i, .rst_ni, .in_ready_o, .fab_data_o, .fab_valid_o, .fab_last_o, .fab_ready_i,
  .eg_valid_i, .out_valid_o, .out_last_o, .out_err_o, .cnt_idx_i, .cnt_clr_i, .cnt_val_o
);

// File: tb/fab_csum_guard_tb_top.sv
module fab_csum_guard_tb_top;
  localparam int MAXB = 16;
  localparam int NP   = 4;
  localparam int CW   = 3;
  localparam int PW   = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] in_data_i = '0, eg_data_i = '0;
  logic in_valid_i = 0, in_last_i = 0, fab_ready_i = 0;
  logic eg_valid_i = 0, eg_last_i = 0, out_ready_i = 0, cnt_clr_i = 0;
  logic [PW-1:0] eg_port_i = '0, cnt_idx_i = '0;
  logic in_ready_o, fab_valid_o, fab_last_o, eg_ready_o, out_valid_o, out_last_o, out_err_o;
  logic [7:0] fab_data_o, out_data_o;
  logic [CW-1:0] cnt_val_o;

  always #10 clk_i = ~clk_i;

  fab_csum_guard #(.MAX_BYTES(MAXB), .NPORTS(NP), .CNT_W(CW)) dut_i (.*);

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] pl [64];
  logic [7:0] fr [64];
  logic [7:0] cap [64];
  logic [7:0] eb [64];
  logic [7:0] oc [64];
  int caplen, lastcnt, oclen, olast, oerr, errmid;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, pl[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic int ref_sum(int n);
    int t = 0;
    for (int i = 0; i < n; i += 2) t += pl[i] * 256 + ((i + 1 < n) ? pl[i + 1] : 0);
    while (t > 65535) t = (t % 65536) + (t / 65536);
    return t;
  endfunction

  // builds payload + FCS into fr, returns frame length
  function automatic int build(int n, int seed);
    logic [31:0] f;
    for (int i = 0; i < n; i++) pl[i] = 8'((i * 37 + seed * 11 + 5 + (i * i) * seed) & 255);
    f = ~ref_crc(n);
    for (int i = 0; i < n; i++) fr[i] = pl[i];
    for (int i = 0; i < 4; i++) fr[n + i] = f[8*i +: 8];
    return n + 4;
  endfunction

  task automatic send_in(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      in_valid_i = 1; in_data_i = fr[i]; in_last_i = (i == n - 1);
      #1;
      while (!in_ready_o) begin @(negedge clk_i); #1; end
      if (i == n - 1) chk(!fab_valid_o, "R1 no early output", fab_valid_o, 0);
      @(posedge clk_i);
    end
    @(negedge clk_i);
    in_valid_i = 0; in_last_i = 0;
  endtask

  task automatic collect(bit stall);
    int cyc = 0;
    caplen = 0; lastcnt = 0;
    while (lastcnt == 0 && cyc < 200) begin
      @(negedge clk_i);
      fab_ready_i = stall ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (fab_valid_o && fab_ready_i) begin
        cap[caplen] = fab_data_o; caplen++;
        if (fab_last_o) lastcnt++;
      end
      cyc++;
      @(posedge clk_i);
    end
    @(negedge clk_i);
    fab_ready_i = 0;
  endtask

  task automatic expect_drop(string req);
    int seen = 0;
    repeat (6) begin
      @(negedge clk_i); fab_ready_i = 1; #1;
      if (fab_valid_o) seen++;
    end
    fab_ready_i = 0;
    chk(seen == 0, req, seen, 0);
    chk(in_ready_o == 1, req, in_ready_o, 1);
  endtask

  task automatic check_fab(int n, string req);
    int s = ref_sum(n), bad = 0;
    chk(caplen == n + 2, req, caplen, n + 2);
    chk({cap[0], cap[1]} == 16'(s), {req, " header"}, {cap[0], cap[1]}, s);
    for (int i = 0; i < n; i++) if (cap[i + 2] != pl[i]) bad++;
    chk(bad == 0, {req, " payload"}, bad, 0);
  endtask

  // sends eb[0..n-1] (header+payload) to egress
  task automatic send_eg(int n, int port, bit stall);
    int k = 0;
    oclen = 0; olast = 0; oerr = 0; errmid = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      eg_valid_i = 1; eg_data_i = eb[i]; eg_last_i = (i == n - 1); eg_port_i = PW'(port);
      out_ready_i = stall ? k[0] : 1'b1; k++;
      #1;
      while (!eg_ready_o) begin
        @(negedge clk_i); out_ready_i = stall ? k[0] : 1'b1; k++; #1;
      end
      if (out_valid_o && out_ready_i) begin
        oc[oclen] = out_data_o; oclen++;
        if (out_last_o) begin olast++; oerr = out_err_o; end
        else if (out_err_o) errmid++;
      end
      @(posedge clk_i);
    end
    @(negedge clk_i);
    eg_valid_i = 0; eg_last_i = 0;
  endtask

  task automatic eg_frame(int n, int seed, int port, bit bad, bit stall);
    int s, m = 0;
    void'(build(n, seed));
    s = ref_sum(n) ^ (bad ? 1 : 0);
    eb[0] = 8'(s >> 8); eb[1] = 8'(s);
    for (int i = 0; i < n; i++) eb[i + 2] = pl[i];
    send_eg(n + 2, port, stall);
    chk(oclen == n, "R7 stripped length", oclen, n);
    for (int i = 0; i < n; i++) if (oc[i] != pl[i]) m++;
    chk(m == 0 && olast == 1, "R7 payload forwarded", m, 0);
    chk(oerr == int'(bad) && errmid == 0, "R8 error flag", oerr, int'(bad));
  endtask

  task automatic read_cnt(int p, output int v);
    @(negedge clk_i); cnt_idx_i = PW'(p); #1; v = cnt_val_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, v;
    repeat (3) @(posedge clk_i);
    #1;
    chk(in_ready_o == 1 && fab_valid_o == 0, "R11 reset ready", in_ready_o, 1);
    chk(cnt_val_o == 0, "R11 reset counter", cnt_val_o, 0);
    @(negedge clk_i); rst_ni = 1;
    for (int p = 0; p < NP; p++) begin
      read_cnt(p, v); chk(v == 0, "R11 counters zero", v, 0);
    end

    // R2 R5 R6: every payload length up to the buffer limit
    for (int len = 1; len <= MAXB - 4; len++) begin
      n = build(len, len);
      send_in(n);
      collect(len[0]);
      check_fab(len, "R5 R6 frame");
      chk(lastcnt == 1, "R5 single last", lastcnt, 1);
    end

    // R3 corrupted payload, then good frame follows
    n = build(6, 9); fr[2] ^= 8'h10;
    send_in(n); expect_drop("R3 bad payload dropped");
    n = build(6, 9); fr[n - 1] ^= 8'h80;
    send_in(n); expect_drop("R2 bad FCS dropped");
    n = build(7, 3); send_in(n); collect(0); check_fab(7, "R3 recovery");

    // R4 too short and too long
    n = build(0, 1); send_in(n); expect_drop("R4 short dropped");
    n = build(MAXB - 3, 2); send_in(n); expect_drop("R4 long dropped");
    n = build(MAXB - 4, 4); send_in(n); collect(1); check_fab(MAXB - 4, "R4 max length");

    // R7 R8 egress matches on all ports
    for (int p = 0; p < NP; p++)
      for (int len = 1; len <= 7; len += 2) eg_frame(len + p, len + 5 * p, p, 0, len[1]);
    for (int p = 0; p < NP; p++) begin
      read_cnt(p, v); chk(v == 0, "R9 no count on match", v, 0);
    end

    // R9 mismatches
    eg_frame(5, 7, 1, 1, 0);
    eg_frame(4, 8, 1, 1, 1);
    eg_frame(3, 2, 3, 1, 0);
    read_cnt(1, v); chk(v == 2, "R9 port1 count", v, 2);
    read_cnt(3, v); chk(v == 1, "R9 port3 count", v, 1);
    read_cnt(0, v); chk(v == 0, "R9 port0 untouched", v, 0);
    for (int i = 0; i < 9; i++) eg_frame(2 + i, i, 2, 1, 0);
    read_cnt(2, v); chk(v == 7, "R9 saturation", v, 7);
    read_cnt(1, v); chk(v == 2, "R9 port1 unchanged", v, 2);

    // R10 clear
    @(negedge clk_i); cnt_idx_i = 2; cnt_clr_i = 1;
    @(negedge clk_i); cnt_clr_i = 0; #1;
    chk(cnt_val_o == 0, "R10 clear", cnt_val_o, 0);
    read_cnt(1, v); chk(v == 2, "R10 clear is per port", v, 2);

    // end to end: ingress output fed to egress
    n = build(9, 12); send_in(n); collect(0); check_fab(9, "R5 end-to-end");
    for (int i = 0; i < caplen; i++) eb[i] = cap[i];
    send_eg(caplen, 0, 1);
    chk(oclen == 9 && oerr == 0, "R8 end-to-end no error", oerr, 0);
    cap[4] ^= 8'h01;
    for (int i = 0; i < caplen; i++) eb[i] = cap[i];
    send_eg(caplen, 0, 0);
    chk(oclen == 9 && oerr == 1, "R8 end-to-end corrupted", oerr, 1);
    read_cnt(0, v); chk(v == 1, "R9 end-to-end count", v, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule